// File: doc/BRIEF.md
# Masked-Page Translation Buffer

This block is a small fully associative translation buffer. Each slot holds a virtual page tag, a per-slot page mask, an address-space tag, a global flag, and two physical frame numbers. The frame numbers cover an even/odd page pair, and each half has its own valid flag. A purely combinational lookup port compares a virtual page number and the current address-space tag against every slot at once. It reports whether a slot matched, the index of that slot, which half of the pair was addressed, and the frame number of that half when the half is valid.

Software-style maintenance goes through a write port that replaces the slot at an explicit index, and through a flush input that empties the whole table. A round-robin pointer names the slot a refill should use next. The valid state of that slot is visible, and a one-cycle advance request steps the pointer, wrapping at the table size. Writes, flushes and pointer steps take effect at the next rising clock edge. An active-low asynchronous reset acts like a flush.

Top module: `mpt_tlb`

## Requirements
- R1: A slot's tag matches when `lk_vpn` equals the stored tag on every bit where the slot's mask is 0. Mask bit k covers tag bit k for k below MASK_W. Tag bits at or above MASK_W are always compared.
- R2: A slot with its global flag clear matches only when its stored address-space tag equals `lk_asid`. A slot with the flag set ignores `lk_asid`.
- R3: When several slots match, `lk_idx` reports the lowest matching index.
- R4: With no matching slot, `lk_match` is 0, `lk_hit` is 0, `lk_idx` is all ones, and `lk_half` and `lk_pfn` are 0.
- R5: A slot takes part in matching only when at least one of its two valid flags is set.
- R6: For a matching slot, `lk_half` is 1 (odd) when the mask is non-zero and the `lk_vpn` bit at the mask's highest set position is 1. Otherwise `lk_half` is 0 (even). `lk_hit` is 1 only when the chosen half's valid flag is set. `lk_pfn` is that half's frame number while `lk_hit` is 1, and 0 otherwise.
- R7: A write with `wr_idx` below ENTRIES replaces every field of that slot at the next rising edge. The old contents leave no trace.
- R8: A write with `wr_idx` at or above ENTRIES changes no slot. `wr_err` is 1 for exactly the one cycle after that edge, and it is 0 in every other cycle.
- R9: `flush` clears every slot, including both valid flags, and sets `nxt_ptr` to 0. It overrides a write or advance in the same cycle, and it raises no `wr_err`. Reset gives the same state.
- R10: `nxt_adv` moves `nxt_ptr` to (`nxt_ptr`+1) mod ENTRIES at the next edge. Without `nxt_adv` the pointer holds. `nxt_valid` shows whether either valid flag of the slot at `nxt_ptr` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all slots and the pointer |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_match | output | 1 | Some valid slot matched |
| lk_hit | output | 1 | Match and the chosen half is valid |
| lk_idx | output | IDX_W | Matching index, all ones on miss |
| lk_half | output | 1 | 0 even, 1 odd half selected |
| lk_pfn | output | PFN_W | Frame number of the chosen half |
| wr_en | input | 1 | Write request |
| wr_idx | input | IDX_W+1 | Target slot index |
| wr_vpn | input | VPN_W | Tag to store |
| wr_mask | input | MASK_W | Page mask to store |
| wr_asid | input | ASID_W | Address-space tag to store |
| wr_glob | input | 1 | Global flag to store |
| wr_v0 | input | 1 | Even-half valid flag |
| wr_v1 | input | 1 | Odd-half valid flag |
| wr_pfn0 | input | PFN_W | Even-half frame number |
| wr_pfn1 | input | PFN_W | Odd-half frame number |
| wr_err | output | 1 | Out-of-range write seen last edge |
| nxt_adv | input | 1 | Step the round-robin pointer |
| nxt_ptr | output | IDX_W | Round-robin pointer |
| nxt_valid | output | 1 | Slot at pointer holds a valid half |

## Verification
Every slot is filled with a distinct mask width, from no masked bits up to fifteen, while the upper tag bits are kept unique. The lookup patterns then flip one low tag bit at a time. Whether a match survives shows exactly which bits each mask excludes, and the flipped top-of-mask bit drives both halves of the pair, including halves whose valid flag is clear. Each lookup is repeated with the stored and with a foreign address-space tag, which separates global slots from private ones. Overlapping slots with different indices and a slot with both valid flags clear show the lowest-index priority and the exclusion of empty slots. The write, pointer and flush checks add out-of-range indices and a flush that coincides with a write and an advance.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
   // Which half of an even/odd page pair a lookup addresses
   typedef enum logic {
      HALF_EVEN = 1'b0,
      HALF_ODD  = 1'b1
   } half_e;
endpackage

// File: rtl/tlbm_store.sv
module tlbm_store #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int MASK_W  = 16,
   parameter int PFN_W   = 24,
   parameter int WIDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glob,
   input  logic              wr_v0,
   input  logic              wr_v1,
   input  logic [PFN_W-1:0]  wr_pfn0,
   input  logic [PFN_W-1:0]  wr_pfn1,
   output logic [VPN_W-1:0]  e_vpn  [ENTRIES],
   output logic [MASK_W-1:0] e_mask [ENTRIES],
   output logic [ASID_W-1:0] e_asid [ENTRIES],
   output logic              e_glob [ENTRIES],
   output logic              e_v0   [ENTRIES],
   output logic              e_v1   [ENTRIES],
   output logic [PFN_W-1:0]  e_pfn0 [ENTRIES],
   output logic [PFN_W-1:0]  e_pfn1 [ENTRIES],
   output logic              wr_err
);
   localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(ENTRIES);

   logic bad_wr;
   assign bad_wr = wr_en && (wr_idx >= LIMIT);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == WIDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_vpn[i]  <= '0;
            e_mask[i] <= '0;
            e_asid[i] <= '0;
            e_glob[i] <= 1'b0;
            e_v0[i]   <= 1'b0;
            e_v1[i]   <= 1'b0;
            e_pfn0[i] <= '0;
            e_pfn1[i] <= '0;
         end else if (flush) begin
            e_vpn[i]  <= '0;
            e_mask[i] <= '0;
            e_asid[i] <= '0;
            e_glob[i] <= 1'b0;
            e_v0[i]   <= 1'b0;
            e_v1[i]   <= 1'b0;
            e_pfn0[i] <= '0;
            e_pfn1[i] <= '0;
         end else if (sel) begin
            e_vpn[i]  <= wr_vpn;
            e_mask[i] <= wr_mask;
            e_asid[i] <= wr_asid;
            e_glob[i] <= wr_glob;
            e_v0[i]   <= wr_v0;
            e_v1[i]   <= wr_v1;
            e_pfn0[i] <= wr_pfn0;
            e_pfn1[i] <= wr_pfn1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_err <= 1'b0;
      else        wr_err <= bad_wr && !flush;
   end
endmodule

// File: rtl/tlbm_cmp.sv
module tlbm_cmp #(
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8,
   parameter int MASK_W = 16
) (
   input  logic [VPN_W-1:0]  key_vpn,
   input  logic [ASID_W-1:0] key_asid,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [MASK_W-1:0] e_mask,
   input  logic [ASID_W-1:0] e_asid,
   input  logic              e_glob,
   input  logic              e_v0,
   input  logic              e_v1,
   output logic              hit
);
   logic [VPN_W-1:0] dont_care;
   logic             tag_ok;
   logic             asid_ok;

   assign dont_care = VPN_W'(e_mask);
   assign tag_ok    = ((key_vpn ^ e_vpn) & ~dont_care) == '0;
   assign asid_ok   = e_glob || (key_asid == e_asid);
   assign hit       = (e_v0 || e_v1) && tag_ok && asid_ok;
endmodule

// File: rtl/tlbm_pick.sv
module tlbm_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
   assign found = |req;
endmodule

// File: rtl/tlbm_rr.sv
module tlbm_rr #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr <= '0;
      else if (flush) ptr <= '0;
      else if (adv)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/mpt_tlb.sv
module mpt_tlb #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int MASK_W  = 16,
   parameter int PFN_W   = 24,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int WIDX_W = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_match,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_idx,
   output logic              lk_half,
   output logic [PFN_W-1:0]  lk_pfn,
   input  logic              wr_en,
   input  logic [WIDX_W-1:0] wr_idx,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic              wr_glob,
   input  logic              wr_v0,
   input  logic              wr_v1,
   input  logic [PFN_W-1:0]  wr_pfn0,
   input  logic [PFN_W-1:0]  wr_pfn1,
   output logic              wr_err,
   input  logic              nxt_adv,
   output logic [IDX_W-1:0]  nxt_ptr,
   output logic              nxt_valid
);
   import tlbm_pkg::*;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (MASK_W > VPN_W) begin : g_bad_mask
      $error("MASK_W must not exceed VPN_W");
   end
   if (ASID_W < 1 || PFN_W < 1) begin : g_bad_width
      $error("ASID_W and PFN_W must be positive");
   end

   logic [VPN_W-1:0]  e_vpn  [ENTRIES];
   logic [MASK_W-1:0] e_mask [ENTRIES];
   logic [ASID_W-1:0] e_asid [ENTRIES];
   logic              e_glob [ENTRIES];
   logic              e_v0   [ENTRIES];
   logic              e_v1   [ENTRIES];
   logic [PFN_W-1:0]  e_pfn0 [ENTRIES];
   logic [PFN_W-1:0]  e_pfn1 [ENTRIES];

   tlbm_store #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
      .MASK_W(MASK_W), .PFN_W(PFN_W), .WIDX_W(WIDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
      .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_v0(wr_v0), .wr_v1(wr_v1),
      .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1),
      .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
      .e_v0(e_v0), .e_v1(e_v1), .e_pfn0(e_pfn0), .e_pfn1(e_pfn1),
      .wr_err(wr_err)
   );

   logic [ENTRIES-1:0] slot_hit;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      tlbm_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W), .MASK_W(MASK_W)) u_cmp (
         .key_vpn(lk_vpn), .key_asid(lk_asid),
         .e_vpn(e_vpn[i]), .e_mask(e_mask[i]), .e_asid(e_asid[i]),
         .e_glob(e_glob[i]), .e_v0(e_v0[i]), .e_v1(e_v1[i]),
         .hit(slot_hit[i])
      );
   end

   logic             pk_found;
   logic [IDX_W-1:0] pk_idx;

   tlbm_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
      .req(slot_hit), .found(pk_found), .idx(pk_idx)
   );

   // Pair select: the tag bit at the highest masked position picks the half
   logic [MASK_W-1:0] sel_mask;
   half_e             half;
   logic              half_ok;
   logic [PFN_W-1:0]  half_pfn;

   assign sel_mask = e_mask[pk_idx];

   always_comb begin
      half = HALF_EVEN;
      for (int k = 0; k < MASK_W; k++) begin
         if (sel_mask[k]) half = lk_vpn[k] ? HALF_ODD : HALF_EVEN;
      end
   end

   assign half_ok  = (half == HALF_ODD) ? e_v1[pk_idx] : e_v0[pk_idx];
   assign half_pfn = (half == HALF_ODD) ? e_pfn1[pk_idx] : e_pfn0[pk_idx];

   assign lk_match = pk_found;
   assign lk_idx   = pk_found ? pk_idx : '1;
   assign lk_half  = pk_found && (half == HALF_ODD);
   assign lk_hit   = pk_found && half_ok;
   assign lk_pfn   = (pk_found && half_ok) ? half_pfn : '0;

   tlbm_rr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
      .clk(clk), .rst_n(rst_n), .flush(flush), .adv(nxt_adv), .ptr(nxt_ptr)
   );

   assign nxt_valid = e_v0[nxt_ptr] || e_v1[nxt_ptr];
endmodule

// File: rtl/tlbm_chk.sv
module tlbm_chk #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4,
   parameter int WIDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush,
   input logic              wr_en,
   input logic [WIDX_W-1:0] wr_idx,
   input logic              wr_err,
   input logic              nxt_adv,
   input logic [IDX_W-1:0]  nxt_ptr,
   input logic              nxt_valid,
   input logic              lk_match,
   input logic              lk_hit,
   input logic [IDX_W-1:0]  lk_idx
);
   logic             bad_req;
   logic [IDX_W-1:0] exp_step;

   assign bad_req  = wr_en && !flush && (wr_idx >= WIDX_W'(ENTRIES));
   assign exp_step = (nxt_ptr == IDX_W'(ENTRIES - 1)) ? '0 : nxt_ptr + 1'b1;

   a_r4_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_match |-> (lk_idx == '1 && !lk_hit));

   a_r6_hit_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_match);

   a_r8_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
      bad_req |=> wr_err);

   a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_req |=> !wr_err);

   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (nxt_ptr == '0 && !nxt_valid));

   a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
      (nxt_adv && !flush) |=> nxt_ptr == $past(exp_step));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!nxt_adv && !flush) |=> $stable(nxt_ptr));
endmodule

bind mpt_tlb tlbm_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .WIDX_W(WIDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_idx(wr_idx),
   .wr_err(wr_err), .nxt_adv(nxt_adv), .nxt_ptr(nxt_ptr), .nxt_valid(nxt_valid),
   .lk_match(lk_match), .lk_hit(lk_hit), .lk_idx(lk_idx)
);

// File: tb/mpt_tlb_test.sv
module mpt_tlb_test;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;
   localparam logic [15:0] LOW = 16'hA5C3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_match, lk_hit, lk_half;
   logic [3:0]  lk_idx;
   logic [23:0] lk_pfn;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_idx = '0;
   logic [19:0] wr_vpn = '0;
   logic [15:0] wr_mask = '0;
   logic [7:0]  wr_asid = '0;
   logic        wr_glob = 1'b0, wr_v0 = 1'b0, wr_v1 = 1'b0;
   logic [23:0] wr_pfn0 = '0, wr_pfn1 = '0;
   logic        wr_err;
   logic        nxt_adv = 1'b0;
   logic [3:0]  nxt_ptr;
   logic        nxt_valid;

   int n_chk = 0;
   int n_fail = 0;

   // reference table kept by the bench
   logic [19:0] m_vpn  [N];
   logic [15:0] m_mask [N];
   logic [7:0]  m_asid [N];
   logic        m_glob [N];
   logic        m_v0   [N];
   logic        m_v1   [N];
   logic [23:0] m_pfn0 [N];
   logic [23:0] m_pfn1 [N];

   mpt_tlb uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_match(lk_match), .lk_hit(lk_hit),
      .lk_idx(lk_idx), .lk_half(lk_half), .lk_pfn(lk_pfn),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
      .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_v0(wr_v0), .wr_v1(wr_v1),
      .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1), .wr_err(wr_err),
      .nxt_adv(nxt_adv), .nxt_ptr(nxt_ptr), .nxt_valid(nxt_valid)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < N; i++) begin
         m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_glob[i] = 1'b0;
         m_v0[i] = 1'b0; m_v1[i] = 1'b0; m_pfn0[i] = '0; m_pfn1[i] = '0;
      end
   endtask

   // expected {match, hit, idx, half, pfn} from R1..R6
   function automatic logic [30:0] model(input logic [19:0] v, input logic [7:0] a);
      logic       m = 1'b0;
      logic [3:0] ix = 4'hF;
      logic       odd = 1'b0;
      logic       hv;
      logic [23:0] pf;
      for (int i = N - 1; i >= 0; i--) begin
         logic care_ok;
         care_ok = (((v ^ m_vpn[i]) & ~{4'h0, m_mask[i]}) == 20'h0);
         if ((m_v0[i] || m_v1[i]) && care_ok && (m_glob[i] || a == m_asid[i])) begin
            m = 1'b1;
            ix = 4'(i);
         end
      end
      if (!m) return {1'b0, 1'b0, 4'hF, 1'b0, 24'h0};
      for (int k = 0; k < 16; k++) if (m_mask[ix][k]) odd = v[k];
      hv = odd ? m_v1[ix] : m_v0[ix];
      pf = hv ? (odd ? m_pfn1[ix] : m_pfn0[ix]) : 24'h0;
      return {1'b1, hv, ix, odd, pf};
   endfunction

   task automatic look(input string req, input logic [19:0] v, input logic [7:0] a);
      lk_vpn = v;
      lk_asid = a;
      #1;
      check(req, 64'({lk_match, lk_hit, lk_idx, lk_half, lk_pfn}), 64'(model(v, a)));
   endtask

   task automatic write(input logic [4:0] idx, input logic [19:0] v, input logic [15:0] mk,
                        input logic [7:0] a, input logic g, input logic e0, input logic e1,
                        input logic [23:0] p0, input logic [23:0] p1);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_vpn = v; wr_mask = mk; wr_asid = a;
      wr_glob = g; wr_v0 = e0; wr_v1 = e1; wr_pfn0 = p0; wr_pfn1 = p1;
      @(negedge clk);
      wr_en = 1'b0;
      if (idx < 5'(N)) begin
         m_vpn[idx[3:0]] = v; m_mask[idx[3:0]] = mk; m_asid[idx[3:0]] = a;
         m_glob[idx[3:0]] = g; m_v0[idx[3:0]] = e0; m_v1[idx[3:0]] = e1;
         m_pfn0[idx[3:0]] = p0; m_pfn1[idx[3:0]] = p1;
      end
   endtask

   // per-slot sweep: exact tag, single-bit flips, coarse steps, own and foreign tag
   task automatic sweep(input string req);
      for (int u = 0; u < N; u++) begin
         for (int s = 0; s < 2; s++) begin
            logic [7:0] a;
            a = 8'(u) ^ 8'(s);
            look(req, {4'(u), LOW}, a);
            for (int b = 0; b < 16; b++) look(req, {4'(u), LOW ^ (16'h1 << b)}, a);
            for (int c = 0; c < 16; c++) look(req, {4'(u), 16'(c * 16'h1111)}, a);
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      model_clear();
      #(CLK_PERIOD * 2 + 3);
      // R9: reset state
      check("R9 reset ptr", 64'(nxt_ptr), 64'd0);
      check("R9 reset valid", 64'(nxt_valid), 64'd0);
      check("R8 reset err", 64'(wr_err), 64'd0);
      rst_n = 1'b1;
      look("R4 empty miss", {4'd3, LOW}, 8'd3);

      // R7: fill slot i, mask covers low i bits, global on every fourth slot
      for (int i = 0; i < N; i++)
         write(5'(i), {4'(i), LOW}, 16'((32'h1 << i) - 1), 8'(i), (i % 4) == 0,
               1'b1, 1'(i % 2), 24'h100 + 24'(2 * i), 24'h101 + 24'(2 * i));
      sweep("R1 R2 R5 R6 masked compare");

      // R3: slots 2 and 11 alias slot 7, fully masked and global
      write(5'd2,  {4'd7, LOW}, 16'hFFFF, 8'h55, 1'b1, 1'b1, 1'b1, 24'hAAA000, 24'hAAA001);
      write(5'd11, {4'd7, LOW}, 16'hFFFF, 8'h66, 1'b1, 1'b1, 1'b0, 24'hBBB000, 24'hBBB001);
      look("R3 lowest index wins", {4'd7, LOW}, 8'd7);
      check("R3 idx", 64'(lk_idx), 64'd2);
      look("R7 old slot 2 gone", {4'd2, LOW}, 8'd2);
      check("R7 old tag misses", 64'(lk_match), 64'd0);
      sweep("R3 R7 overlap");

      // R5: slot 2 keeps its tag but drops both valid flags
      write(5'd2, {4'd7, LOW}, 16'hFFFF, 8'h55, 1'b1, 1'b0, 1'b0, 24'hAAA000, 24'hAAA001);
      look("R5 empty slot skipped", {4'd7, LOW}, 8'd7);
      check("R5 idx", 64'(lk_idx), 64'd7);
      sweep("R5 invalid slot");

      // R8: out-of-range writes
      for (int w = 16; w < 32; w += 15) begin
         @(negedge clk);
         wr_en = 1'b1; wr_idx = 5'(w); wr_vpn = {4'd9, LOW}; wr_mask = 16'hFFFF;
         wr_asid = 8'd0; wr_glob = 1'b1; wr_v0 = 1'b1; wr_v1 = 1'b1;
         wr_pfn0 = 24'hDEAD00; wr_pfn1 = 24'hDEAD01;
         @(negedge clk);
         wr_en = 1'b0;
         check("R8 err pulse", 64'(wr_err), 64'd1);
         @(negedge clk);
         check("R8 err single cycle", 64'(wr_err), 64'd0);
      end
      sweep("R8 table unchanged");

      // R10: stepping and wrap
      for (int s = 0; s < 20; s++) begin
         check("R10 ptr", 64'(nxt_ptr), 64'(s % N));
         check("R10 valid", 64'(nxt_valid), 64'(m_v0[s % N] || m_v1[s % N]));
         @(negedge clk); nxt_adv = 1'b1;
         @(negedge clk); nxt_adv = 1'b0;
      end
      @(negedge clk);
      check("R10 hold", 64'(nxt_ptr), 64'd4);

      // R9: flush with a write and an advance in the same cycle
      @(negedge clk);
      flush = 1'b1; nxt_adv = 1'b1;
      wr_en = 1'b1; wr_idx = 5'd3; wr_vpn = {4'd3, LOW}; wr_mask = '0;
      wr_asid = 8'd3; wr_glob = 1'b1; wr_v0 = 1'b1; wr_v1 = 1'b1;
      @(negedge clk);
      flush = 1'b0; nxt_adv = 1'b0; wr_en = 1'b0;
      model_clear();
      check("R9 flush ptr", 64'(nxt_ptr), 64'd0);
      check("R9 flush no err", 64'(wr_err), 64'd0);
      sweep("R9 flushed table");
      for (int s = 0; s < N; s++) begin
         check("R9 slot cleared", 64'(nxt_valid), 64'd0);
         @(negedge clk); nxt_adv = 1'b1;
         @(negedge clk); nxt_adv = 1'b0;
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule